// File: doc/BRIEF.md
# Processor Status and Reset Sequencer

This block keeps the live status word of a small 32-bit processor core and runs the start-up sequence that follows an active-low core reset. The status word carries a 5-bit operating-mode field, a disable bit for the normal interrupt line, a disable bit for the fast interrupt line, and a state bit that selects the compact 16-bit instruction encoding. The block also owns the instruction fetch address. While reset is held low, the fetch address keeps stepping as if fetches were still going on. On release, the block banks the old fetch address and status word into supervisor copies, forces supervisor mode with both interrupts disabled and the standard instruction state, and restarts fetch at address zero.

Both interrupt request lines arrive asynchronously. They pass through a multi-stage synchronizer and are then qualified by the matching disable bit. A one-cycle done strobe marks the end of the start-up sequence. Before that strobe has been issued, the block raises no interrupt and accepts no status write. In normal running, the core rewrites the status word through a write strobe and advances fetch through an advance strobe.

Top module: `core_status_seq`

## Requirements
- R1: The status word holds the mode in bits [4:0], the compact-state bit in bit 5, the fast-interrupt disable in bit 6 and the normal-interrupt disable in bit 7. Bits [31:8] always read zero, whatever value is written.
- R2: While `core_rst_n` is low at a clock edge, the status word, `svc_link` and `svc_saved` keep their values. `seq_done`, `irq_take` and `fiq_take` are low. `fetch_addr` grows by 4 when bit 5 is clear and by 2 when it is set.
- R3: At the first clock edge where `core_rst_n` is high after being low, `svc_link` takes the `fetch_addr` value held before that edge, and `svc_saved` takes the status word held before that edge.
- R4: At that same edge the status word becomes 0x000000D3: mode 5'b10011, both disable bits set, compact-state bit clear.
- R5: At that same edge `fetch_addr` becomes 0x00000000, and `state_out` goes low.
- R6: `seq_done` is high for exactly the one cycle that follows the sequence edge.
- R7: `state_out` always equals status bit 5.
- R8: `irq_take` rises only when the synchronized normal request is high and status bit 7 was clear.
- R9: `fiq_take` rises only when the synchronized fast request is high and status bit 6 was clear.
- R10: A request held high with its disable bit clear first shows on its take output after the fourth rising clock edge that samples it.
- R11: Until `seq_done` has been issued, both take outputs stay low and `sts_wr` has no effect on the status word.
- R12: In normal running, each edge with `fetch_adv` high advances `fetch_addr` by 4 when bit 5 is clear and by 2 when it is set. Without `fetch_adv`, `fetch_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| core_rst_n | input | 1 | Active-low core reset, sampled on the clock |
| irq_req_async | input | 1 | Normal interrupt request, asynchronous |
| fiq_req_async | input | 1 | Fast interrupt request, asynchronous |
| sts_wr | input | 1 | Status word write strobe |
| sts_wdata | input | 32 | Status word write value |
| fetch_adv | input | 1 | Advance fetch address by one instruction |
| status_word | output | 32 | Current status word |
| state_out | output | 1 | High in compact state, low in standard state |
| fetch_addr | output | 32 | Instruction fetch address |
| svc_link | output | 32 | Supervisor link copy of the fetch address |
| svc_saved | output | 32 | Supervisor saved copy of the status word |
| seq_done | output | 1 | One-cycle strobe after the reset sequence |
| irq_take | output | 1 | Qualified normal interrupt |
| fiq_take | output | 1 | Qualified fast interrupt |

## Verification
The assertions check every cycle that the reserved status bits read zero and that the state output mirrors bit 5. They also check that status is frozen and fetch keeps stepping while reset is low, that the done strobe lasts one cycle and coincides with the forced supervisor status at fetch address zero, and that no take output fires against its disable bit or during the done cycle. Some behaviours can only be shown by the bench scenarios, because they depend on a chosen history of events. These are the exact values banked into the supervisor copies, the four-edge synchronizer latency, the step size in each instruction state during normal fetch, and the rejection of a status write held across the reset release.

// File: rtl/core_status_pkg.sv
package core_status_pkg;

    localparam int STAT_W = 32;
    localparam int MODE_W = 5;
    localparam logic [MODE_W-1:0] MODE_SUPERVISOR = 5'b10011;
    localparam int STEP_STD = 4;
    localparam int STEP_CMP = 2;

    // Field order gives mode [4:0], compact bit 5, fast-off bit 6, irq-off bit 7
    typedef struct packed {
        logic              irq_off;
        logic              fiq_off;
        logic              compact;
        logic [MODE_W-1:0] mode;
    } stat_t;

    localparam int STAT_USED = $bits(stat_t);

    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,
        SEQ_DONE = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_e;

    function automatic logic [STAT_W-1:0] stat_to_word(input stat_t s);
        logic [STAT_W-1:0] w;
        w = '0;
        w[STAT_USED-1:0] = s;
        return w;
    endfunction

    function automatic stat_t word_to_stat(input logic [STAT_W-1:0] w);
        return stat_t'(w[STAT_USED-1:0]);
    endfunction

    function automatic stat_t stat_after_reset();
        stat_t s;
        s.irq_off = 1'b1;
        s.fiq_off = 1'b1;
        s.compact = 1'b0;
        s.mode    = MODE_SUPERVISOR;
        return s;
    endfunction

endpackage

// File: rtl/core_status_sync.sv
module core_status_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic [LINES-1:0] req_async,
    output logic [LINES-1:0] req_sync
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) chain <= req_async[g];
        end else begin : g_multi
            always_ff @(posedge clk) chain <= {chain[STAGES-2:0], req_async[g]};
        end
        assign req_sync[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/core_status_fsm.sv
module core_status_fsm
    import core_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic save_now,
    output logic running,
    output logic done
);

    seq_e st;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SEQ_HOLD;
        end else begin
            unique case (st)
                SEQ_HOLD: st <= SEQ_DONE;
                SEQ_DONE: st <= SEQ_RUN;
                SEQ_RUN:  st <= SEQ_RUN;
                default:  st <= SEQ_HOLD;
            endcase
        end
    end

    assign save_now = rst_n && (st == SEQ_HOLD);
    assign done     = (st == SEQ_DONE);
    assign running  = (st == SEQ_RUN);

endmodule

// File: rtl/core_status_reg.sv
module core_status_reg
    import core_status_pkg::*;
(
    input  logic              clk,
    input  logic              load_reset,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wdata,
    output stat_t             cur
);

    logic unused_rsvd;
    assign unused_rsvd = ^wdata[STAT_W-1:STAT_USED];

    always_ff @(posedge clk) begin
        if (load_reset) begin
            cur <= stat_after_reset();
        end else if (wr_en) begin
            cur <= word_to_stat(wdata);
        end
    end

endmodule

// File: rtl/core_status_fetch.sv
module core_status_fetch
    import core_status_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              hold,
    input  logic              restart,
    input  logic              adv,
    input  logic              compact,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] step;

    always_comb begin
        step = compact ? ADDR_W'(STEP_CMP) : ADDR_W'(STEP_STD);
    end

    always_ff @(posedge clk) begin
        if (hold) begin
            addr <= addr + step;
        end else if (restart) begin
            addr <= '0;
        end else if (adv) begin
            addr <= addr + step;
        end
    end

endmodule

// File: rtl/core_status_bank.sv
module core_status_bank
    import core_status_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              save,
    input  logic [ADDR_W-1:0] pc_now,
    input  logic [STAT_W-1:0] stat_now,
    output logic [ADDR_W-1:0] link,
    output logic [STAT_W-1:0] saved
);

    always_ff @(posedge clk) begin
        if (save) begin
            link  <= pc_now;
            saved <= stat_now;
        end
    end

endmodule

// File: rtl/core_status_seq.sv
module core_status_seq
    import core_status_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SYNC_STAGES = 3
) (
    input  logic              clk,
    input  logic              core_rst_n,
    input  logic              irq_req_async,
    input  logic              fiq_req_async,
    input  logic              sts_wr,
    input  logic [STAT_W-1:0] sts_wdata,
    input  logic              fetch_adv,
    output logic [STAT_W-1:0] status_word,
    output logic              state_out,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] svc_link,
    output logic [STAT_W-1:0] svc_saved,
    output logic              seq_done,
    output logic              irq_take,
    output logic              fiq_take
);

    localparam int IRQ_LINE = 0;
    localparam int FIQ_LINE = 1;
    localparam int N_LINES  = 2;

    logic               save_now;
    logic               running;
    stat_t              cur;
    logic [N_LINES-1:0] req_sync;
    logic [N_LINES-1:0] take_q;
    logic [N_LINES-1:0] line_off;

    core_status_fsm u_fsm (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .save_now (save_now),
        .running  (running),
        .done     (seq_done)
    );

    core_status_reg u_stat (
        .clk        (clk),
        .load_reset (save_now),
        .wr_en      (running && core_rst_n && sts_wr),
        .wdata      (sts_wdata),
        .cur        (cur)
    );

    assign status_word = stat_to_word(cur);
    assign state_out   = cur.compact;

    core_status_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk     (clk),
        .hold    (!core_rst_n),
        .restart (save_now),
        .adv     (running && fetch_adv),
        .compact (cur.compact),
        .addr    (fetch_addr)
    );

    core_status_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .save     (save_now),
        .pc_now   (fetch_addr),
        .stat_now (status_word),
        .link     (svc_link),
        .saved    (svc_saved)
    );

    core_status_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .req_async ({fiq_req_async, irq_req_async}),
        .req_sync  (req_sync)
    );

    assign line_off[IRQ_LINE] = cur.irq_off;
    assign line_off[FIQ_LINE] = cur.fiq_off;

    for (genvar g = 0; g < N_LINES; g++) begin : g_take
        always_ff @(posedge clk) take_q[g] <= req_sync[g] & ~line_off[g];
    end

    assign irq_take = take_q[IRQ_LINE] & running;
    assign fiq_take = take_q[FIQ_LINE] & running;

endmodule

// File: rtl/core_status_seq_chk.sv
module core_status_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              core_rst_n,
    input logic [31:0]       status_word,
    input logic              state_out,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              seq_done,
    input logic              irq_take,
    input logic              fiq_take
);

    logic [2:0] age = 3'b000;
    logic       armed;

    always_ff @(posedge clk) age <= {age[1:0], 1'b1};
    assign armed = age[2];

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!armed)
        status_word[31:8] == 24'h0);

    assert_hold_frozen_R2: assert property (@(posedge clk) disable iff (!armed)
        !core_rst_n |=> $stable(status_word) && !seq_done && !irq_take && !fiq_take);

    assert_hold_fetch_R2: assert property (@(posedge clk) disable iff (!armed)
        !core_rst_n |=> (fetch_addr - $past(fetch_addr)) ==
                        ($past(status_word[5]) ? ADDR_W'(2) : ADDR_W'(4)));

    // R5 is covered here too: fetch at zero and standard state during the strobe
    assert_forced_status_R4: assert property (@(posedge clk) disable iff (!armed)
        seq_done |-> status_word[7:0] == 8'hD3 && fetch_addr == '0 && !state_out);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!armed)
        seq_done |=> !seq_done);

    assert_state_mirror_R7: assert property (@(posedge clk) disable iff (!armed)
        state_out == status_word[5]);

    assert_irq_mask_R8: assert property (@(posedge clk) disable iff (!armed)
        irq_take |-> $past(!status_word[7]));

    assert_fiq_mask_R9: assert property (@(posedge clk) disable iff (!armed)
        fiq_take |-> $past(!status_word[6]));

    assert_quiet_done_R11: assert property (@(posedge clk) disable iff (!armed)
        seq_done |-> !irq_take && !fiq_take);

endmodule

bind core_status_seq core_status_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .core_rst_n  (core_rst_n),
    .status_word (status_word),
    .state_out   (state_out),
    .fetch_addr  (fetch_addr),
    .seq_done    (seq_done),
    .irq_take    (irq_take),
    .fiq_take    (fiq_take)
);

// File: tb/core_status_seq_test.sv
module core_status_seq_test;

    logic        clk = 1'b0;
    logic        core_rst_n = 1'b0;
    logic        irq_req_async = 1'b0;
    logic        fiq_req_async = 1'b0;
    logic        sts_wr = 1'b0;
    logic [31:0] sts_wdata = '0;
    logic        fetch_adv = 1'b0;
    logic [31:0] status_word;
    logic        state_out;
    logic [31:0] fetch_addr;
    logic [31:0] svc_link;
    logic [31:0] svc_saved;
    logic        seq_done;
    logic        irq_take;
    logic        fiq_take;

    int n_checks = 0;
    int n_fails  = 0;
    bit reported = 1'b0;

    always #10 clk = ~clk;

    core_status_seq uut (
        .clk           (clk),
        .core_rst_n    (core_rst_n),
        .irq_req_async (irq_req_async),
        .fiq_req_async (fiq_req_async),
        .sts_wr        (sts_wr),
        .sts_wdata     (sts_wdata),
        .fetch_adv     (fetch_adv),
        .status_word   (status_word),
        .state_out     (state_out),
        .fetch_addr    (fetch_addr),
        .svc_link      (svc_link),
        .svc_saved     (svc_saved),
        .seq_done      (seq_done),
        .irq_take      (irq_take),
        .fiq_take      (fiq_take)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        end
    endtask

    task automatic write_status(input logic [31:0] v);
        @(negedge clk);
        sts_wr = 1'b1;
        sts_wdata = v;
        @(negedge clk);
        sts_wr = 1'b0;
    endtask

    task automatic t_power_on();
        repeat (4) @(negedge clk);
        core_rst_n = 1'b1;
        @(negedge clk);
        check("R4 forced status", status_word, 32'h0000_00D3);
        check("R5 fetch restart", fetch_addr, 32'h0);
        check("R5 standard state", {31'b0, state_out}, 32'h0);
        check("R6 strobe high", {31'b0, seq_done}, 32'h1);
        @(negedge clk);
        check("R6 strobe one cycle", {31'b0, seq_done}, 32'h0);
    endtask

    task automatic t_layout();
        write_status(32'hABCD_12F1);
        check("R1 reserved bits zero", status_word, 32'h0000_00F1);
        check("R7 state mirror high", {31'b0, state_out}, 32'h1);
        write_status(32'hFFFF_FF10);
        check("R1 fields only", status_word, 32'h0000_0010);
        check("R7 state mirror low", {31'b0, state_out}, 32'h0);
    endtask

    task automatic t_fetch_run();
        logic [31:0] base;
        base = fetch_addr;
        check("R12 hold without advance", fetch_addr, base);
        fetch_adv = 1'b1;
        repeat (3) @(negedge clk);
        fetch_adv = 1'b0;
        check("R12 standard step", fetch_addr, base + 32'd12);
        write_status(32'h0000_0030);
        base = fetch_addr;
        fetch_adv = 1'b1;
        repeat (2) @(negedge clk);
        fetch_adv = 1'b0;
        @(negedge clk);
        check("R12 compact step", fetch_addr, base + 32'd4);
    endtask

    task automatic t_reset_save();
        logic [31:0] exp_f;
        logic [31:0] old_link;
        logic [31:0] old_saved;
        write_status(32'h0000_003F);
        exp_f = fetch_addr;
        old_link = svc_link;
        old_saved = svc_saved;
        core_rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            exp_f = exp_f + 32'd2;
            check("R2 fetch keeps stepping", fetch_addr, exp_f);
            check("R2 status frozen", status_word, 32'h0000_003F);
            check("R2 no strobe", {31'b0, seq_done}, 32'h0);
        end
        check("R2 link untouched", svc_link, old_link);
        check("R2 saved untouched", svc_saved, old_saved);
        core_rst_n = 1'b1;
        @(negedge clk);
        check("R3 link banked", svc_link, exp_f);
        check("R3 status banked", svc_saved, 32'h0000_003F);
        check("R4 forced after save", status_word, 32'h0000_00D3);
        check("R5 fetch zero after save", fetch_addr, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_irq();
        write_status(32'h0000_0013);
        irq_req_async = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 not yet after three edges", {31'b0, irq_take}, 32'h0);
        @(negedge clk);
        check("R10 seen after four edges", {31'b0, irq_take}, 32'h1);
        irq_req_async = 1'b0;
        repeat (5) @(negedge clk);
        write_status(32'h0000_0093);
        irq_req_async = 1'b1;
        repeat (6) @(negedge clk);
        check("R8 masked by bit 7", {31'b0, irq_take}, 32'h0);
        irq_req_async = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_fiq();
        write_status(32'h0000_0053);
        irq_req_async = 1'b1;
        fiq_req_async = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 masked by bit 6", {31'b0, fiq_take}, 32'h0);
        check("R8 normal line still open", {31'b0, irq_take}, 32'h1);
        irq_req_async = 1'b0;
        fiq_req_async = 1'b0;
        repeat (5) @(negedge clk);
        write_status(32'h0000_0013);
        fiq_req_async = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 open when bit 6 clear", {31'b0, fiq_take}, 32'h1);
    endtask

    task automatic t_quiet_until_done();
        @(negedge clk);
        core_rst_n = 1'b0;
        sts_wr = 1'b1;
        sts_wdata = 32'h0000_0013;
        @(negedge clk);
        check("R2 take low in reset", {31'b0, fiq_take}, 32'h0);
        core_rst_n = 1'b1;
        @(negedge clk);
        check("R11 strobe cycle", {31'b0, seq_done}, 32'h1);
        check("R11 no take in strobe cycle", {31'b0, fiq_take}, 32'h0);
        check("R11 write ignored at release", status_word, 32'h0000_00D3);
        @(negedge clk);
        sts_wr = 1'b0;
        check("R11 write ignored during strobe", status_word, 32'h0000_00D3);
        fiq_req_async = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        t_power_on();
        t_layout();
        t_fetch_run();
        t_reset_save();
        t_irq();
        t_fiq();
        t_quiet_until_done();
        report();
        $finish;
    end

endmodule